// File: doc/BRIEF.md
# Periodic Down-Counting Interval Timer

This block is a 16-bit interval timer built around a down counter and a period register. Both are reachable through a small memory-mapped port with an address, a write strobe, write data and combinational read data. Each enabled tick lowers the count by one. On the tick that brings the count to zero, the block emits a single-clock interrupt pulse. On the following tick it loads the count again from the period register, so events recur every period-plus-one ticks.

A select input picks the tick source. With the select low, the counter ticks on every clock. With the select high, it ticks once per four clocks, taken from a free-running phase counter that reset clears. Software can overwrite the count at any time to restart or shift the sequence. A new period value is used only at the next reload.

Top module: `periodic_down_timer`

## Requirements
- R1: While reset is high, and on the first clock after it is released, the count and the period both read 0xFFFF and the interrupt output is low.
- R2: Address 0 selects the count and address 1 selects the period. Reads from addresses 2 and 3 return 0, and writes to them change neither register.
- R3: With the tick select low, a count that is not zero and is not being written drops by exactly one on every clock.
- R4: The interrupt output is high for exactly the one clock after an edge at which a tick moved the count to zero, and it is low at all other times.
- R5: On the tick after the count reached zero, the count reloads with the value held in the period register. With period P at full rate, interrupts therefore recur every P+1 clocks.
- R6: A write to address 0 loads the written value into the count on that edge. The write takes priority over any tick, and no interrupt is produced by it.
- R7: A write to address 1 updates the period register but leaves the current count untouched. The new value is first used at the next reload.
- R8: With the tick select high, the count changes only on every fourth clock after reset is released. The first tick falls on the fourth edge, and the phase counter runs whether or not the select is high.
- R9: With a period of 0, the count stays at 0 and the interrupt output is high after every tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 2 | Register select: 0 for count, 1 for period |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 16 | Value written |
| rd_data | output | 16 | Contents of the selected register (combinational) |
| slow_tick | input | 1 | 1 selects one tick per four clocks, 0 selects one tick per clock |
| irq | output | 1 | One-clock interrupt pulse on each zero event |

## Verification
The decrement and reload properties apply only when the tick select is low. The single-pulse property in divided mode applies only while the select stays high for two clocks in a row. The stimulus satisfies both conditions: it holds the select constant through each phase and changes it only while reset is asserted. Writes are presented for one clock at a time with stable address and data, so each property sees a single write per edge. The divided-mode sequence starts from a reset release, which keeps the phase of every tick known to the bench.

// File: rtl/timer_pkg.sv
package timer_pkg;
   localparam int unsigned REG_COUNT  = 0;
   localparam int unsigned REG_PERIOD = 1;
endpackage

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
   parameter int unsigned DIV = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic slow,
   output logic tick
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   logic [PW-1:0] phase_q;

   generate
      if (DIV < 2) begin : g_bad_div
         $error("timer_tick_gen: DIV must be at least 2");
      end
      if (DIV == (1 << PW)) begin : g_pow2
         always_ff @(posedge clk) begin
            if (rst) phase_q <= '0;
            else     phase_q <= phase_q + 1'b1;
         end
      end else begin : g_any
         always_ff @(posedge clk) begin
            if (rst)                  phase_q <= '0;
            else if (phase_q == LAST) phase_q <= '0;
            else                      phase_q <= phase_q + 1'b1;
         end
      end
   endgenerate

   assign tick = slow ? (phase_q == LAST) : 1'b1;
endmodule

// File: rtl/timer_count_core.sv
module timer_count_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] count,
   output logic             zero_pulse
);
   logic [CNT_W-1:0] step_val;

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("timer_count_core: CNT_W must be at least 2");
      end
   endgenerate

   always_comb begin
      if (count == '0) step_val = period;
      else             step_val = count - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         count      <= '1;
         zero_pulse <= 1'b0;
      end else begin
         zero_pulse <= 1'b0;
         if (load) begin
            count <= load_val;
         end else if (tick) begin
            count      <= step_val;
            zero_pulse <= (step_val == '0);
         end
      end
   end
endmodule

// File: rtl/timer_reg_port.sv
module timer_reg_port
   import timer_pkg::*;
#(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [CNT_W-1:0]  count,
   output logic              count_wr,
   output logic [CNT_W-1:0]  period,
   output logic [CNT_W-1:0]  rd_data
);
   localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(REG_COUNT);
   localparam logic [ADDR_W-1:0] A_PRD = ADDR_W'(REG_PERIOD);

   generate
      if (ADDR_W < 1) begin : g_bad_a
         $error("timer_reg_port: ADDR_W must be at least 1");
      end
   endgenerate

   assign count_wr = wr_en && (addr == A_CNT);

   always_ff @(posedge clk) begin
      if (rst)                          period <= '1;
      else if (wr_en && addr == A_PRD)  period <= wr_data;
   end

   always_comb begin
      case (addr)
         A_CNT:   rd_data = count;
         A_PRD:   rd_data = period;
         default: rd_data = '0;
      endcase
   end
endmodule

// File: rtl/periodic_down_timer.sv
module periodic_down_timer #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DIV    = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [CNT_W-1:0]  wr_data,
   output logic [CNT_W-1:0]  rd_data,
   input  logic              slow_tick,
   output logic              irq
);
   logic             tick;
   logic             cnt_wr;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] prd_q;

   timer_tick_gen #(.DIV(DIV)) u_tick (
      .clk(clk), .rst(rst), .slow(slow_tick), .tick(tick)
   );

   timer_reg_port #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .count(cnt_q), .count_wr(cnt_wr), .period(prd_q), .rd_data(rd_data)
   );

   timer_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst(rst), .tick(tick), .load(cnt_wr), .load_val(wr_data),
      .period(prd_q), .count(cnt_q), .zero_pulse(irq)
   );
endmodule

// File: rtl/periodic_down_timer_chk.sv
module periodic_down_timer_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 2
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [CNT_W-1:0]  wr_data,
   input logic              slow_tick,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  prd
);
   logic wr_c, wr_p;
   assign wr_c = wr_en && (addr == ADDR_W'(0));
   assign wr_p = wr_en && (addr == ADDR_W'(1));

   p_dec_r3: assert property (@(posedge clk) disable iff (rst)
      (!slow_tick && !wr_c && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

   p_irq_zero_r4: assert property (@(posedge clk) disable iff (rst)
      irq |-> (cnt == '0));

   p_reload_r5: assert property (@(posedge clk) disable iff (rst)
      (!slow_tick && !wr_c && cnt == '0) |=> (cnt == $past(prd)));

   p_write_r6: assert property (@(posedge clk) disable iff (rst)
      wr_c |=> (cnt == $past(wr_data) && !irq));

   p_prd_hold_r7: assert property (@(posedge clk) disable iff (rst)
      !wr_p |=> $stable(prd));

   p_slow_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      (irq && slow_tick) |=> (!irq || !slow_tick));
endmodule

bind periodic_down_timer periodic_down_timer_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
   .slow_tick(slow_tick), .irq(irq), .cnt(cnt_q), .prd(prd_q)
);

// File: tb/periodic_down_timer_test.sv
`timescale 1ns/1ps
module periodic_down_timer_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  addr = '0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        slow_tick = 1'b0;
   logic        irq;
   int          errs = 0;
   int          checks = 0;
   int          cycles = 0;

   always #4 clk = ~clk;

   periodic_down_timer uut (
      .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .slow_tick(slow_tick), .irq(irq)
   );

   // entry: {wr_en, addr, wr_data, expected irq, expected rd_data}
   localparam int NV = 17;
   localparam logic [35:0] VEC [NV] = '{
      {1'b1, 2'd1, 16'd2,    1'b0, 16'd2},  // R7 period write, R2 read period
      {1'b1, 2'd0, 16'd3,    1'b0, 16'd3},  // R6 count write overrides
      {1'b0, 2'd0, 16'd0,    1'b0, 16'd2},  // R3 decrement
      {1'b0, 2'd0, 16'd0,    1'b0, 16'd1},  // R3
      {1'b0, 2'd0, 16'd0,    1'b1, 16'd0},  // R4 zero pulse
      {1'b0, 2'd0, 16'd0,    1'b0, 16'd2},  // R5 reload, R4 pulse ends
      {1'b0, 2'd0, 16'd0,    1'b0, 16'd1},  // R5
      {1'b0, 2'd0, 16'd0,    1'b1, 16'd0},  // R5 interval P+1 = 3
      {1'b0, 2'd0, 16'd0,    1'b0, 16'd2},  // R5
      {1'b1, 2'd1, 16'd0,    1'b0, 16'd0},  // R7 period=0, count not touched
      {1'b0, 2'd0, 16'd0,    1'b1, 16'd0},  // R7 count still counted 1->0
      {1'b0, 2'd0, 16'd0,    1'b1, 16'd0},  // R9 period 0 every tick
      {1'b0, 2'd0, 16'd0,    1'b1, 16'd0},  // R9
      {1'b1, 2'd0, 16'd5,    1'b0, 16'd5},  // R6 write, no pulse
      {1'b1, 2'd3, 16'h1234, 1'b0, 16'd0},  // R2 unmapped read 0, write ignored
      {1'b0, 2'd0, 16'd0,    1'b0, 16'd3},  // R2 count unaffected
      {1'b0, 2'd1, 16'd0,    1'b0, 16'd0}   // R2 period unaffected
   };

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic edge_step();
      @(posedge clk);
      #1;
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 5000) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=5000", cycles);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
         end
      end
   end

   initial begin
      edge_step();
      edge_step();
      // R1: state while reset is held
      addr = 2'd0; #1; chk("R1 count reset", rd_data, 16'hFFFF);
      addr = 2'd1; #1; chk("R1 period reset", rd_data, 16'hFFFF);
      chk("R1 irq reset", {15'd0, irq}, 16'd0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         wr_en   = VEC[i][35];
         addr    = VEC[i][34:33];
         wr_data = VEC[i][32:17];
         edge_step();
         chk($sformatf("table[%0d] irq", i), {15'd0, irq}, {15'd0, VEC[i][16]});
         chk($sformatf("table[%0d] rd_data", i), rd_data, VEC[i][15:0]);
      end
      wr_en = 1'b0;

      // R8: divided tick, phase known from reset release
      rst = 1'b1; slow_tick = 1'b1;
      edge_step();
      addr = 2'd0; #1;
      chk("R1 count after re-reset", rd_data, 16'hFFFF);
      rst = 1'b0; wr_en = 1'b1; wr_data = 16'd1;
      edge_step();                       // e1: count=1
      wr_en = 1'b0;
      edge_step();                       // e2
      edge_step();                       // e3
      chk("R8 no tick before 4th edge", rd_data, 16'd1);
      chk("R8 no irq before 4th edge", {15'd0, irq}, 16'd0);
      edge_step();                       // e4: tick -> 0
      chk("R8 tick on 4th edge", rd_data, 16'd0);
      chk("R4 irq on zero (slow)", {15'd0, irq}, 16'd1);
      edge_step();                       // e5
      chk("R4 single pulse (slow)", {15'd0, irq}, 16'd0);
      chk("R8 count held between ticks", rd_data, 16'd0);
      edge_step();                       // e6
      edge_step();                       // e7
      chk("R8 count still held", rd_data, 16'd0);
      edge_step();                       // e8: reload from period 0xFFFF
      chk("R5 reload in slow mode", rd_data, 16'hFFFF);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule